// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block is a free-running calendar clock that counts from a 100 Hz tick enable. It keeps eight byte-wide registers in binary-coded decimal: hundredths of a second, seconds, minutes, hours, day of week, date, month and two-digit year. All eight are visible at once as a single 64-bit image. A serial access engine elsewhere in the chip reads the image and can replace it in one cycle with a bulk load.

The hours register has two formats, 24-hour and 12-hour with a PM flag, and a mode bit selects between them. The day-of-week register also holds two control bits. The first halts counting. The second tells the surrounding logic to ignore its external reset pin; this block only stores that bit. Both control bits are set after reset, so the clock stays halted until software loads the image with the halt bit cleared.

Top module: `bcd_timekeeper`

## Requirements
- R1: While running, each cycle with `tick_i` high adds one to the hundredths register (byte 0, BCD 00..99). At 99 it returns to 00 and carries into seconds. In a cycle with `tick_i` low and `load_i` low, the image does not change.
- R2: Seconds (byte 1, bits 6:0) and minutes (byte 2, bits 6:0) each count 00..59 in BCD. Each wraps to 00 and carries into the next field.
- R3: When hours bit 7 (byte 3) is 0, the hours field counts 00..23 in BCD, using bit 5 as the twenties digit and bit 4 as the tens digit. After 23 comes 00, and that step advances the day.
- R4: When hours bit 7 is 1, the hours field counts 12, 01, 02 .. 11 (tens in bit 4) and bit 5 is the PM flag (1 = PM). The PM flag flips on every 11 to 12 step. The day advances only on the step from 11 PM to 12 AM.
- R5: Day of week sits in byte 4, bits 2:0, and runs 1..7. It wraps from 7 to 1 and advances together with the date.
- R6: The date (byte 5) wraps to 01 after the last day of the month. That day is 30 for months 04, 06, 09 and 11, and 31 for the other months apart from February. The month (byte 6) wraps from 12 to 01 and increments the year (byte 7), which wraps from 99 to 00.
- R7: February ends on 29 when the two-digit year is divisible by 4, year 00 included, and on 28 in every other year.
- R8: While byte 4 bit 5 (halt) is 1, ticks are ignored and the image holds.
- R9: Byte 4 bit 4 (reset-ignore) and bit 5 (halt) change only through a bulk load. Counting, including the day advancing, leaves both untouched.
- R10: Synchronous active-low reset sets the image to 64'h0001_0131_0000_0000: time 00:00:00.00 in 24-hour mode, day 1 with both control bits set, date 01, month 01, year 00.
- R11: A cycle with `load_i` high writes `load_image_i` into all eight registers at once. Byte k sits at bits 8k+7:8k, and the change is seen after that clock edge. Bits that have no meaning always read 0, giving the keep mask 64'hFF1F_3F37_BF7F_7FFF.
- R12: When `load_i` and `tick_i` are both high in the same cycle, the load wins and no increment is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | 100 Hz count enable, one cycle per hundredth |
| load_i | input | 1 | Bulk load strobe |
| load_image_i | input | 64 | Image to load, byte k is register k |
| image_o | output | 64 | Current register image, byte k is register k |

## Verification
A table of single-tick cases starts from carefully chosen boundary images. Each case shows whether a carry stops at the right field: a units digit 9 against a full 99 or 59, 23:59 in 24-hour mode against 11:59 AM and PM in 12-hour mode, and 30-day, 31-day and February month ends. Leap-year cases use years 00, 10, 12, 23 and 24, which separate the even-tens and odd-tens digit rules. Directed runs compare a loaded image held with no ticks, with the halt bit set, and with a load in the same cycle as a tick. A stretch of 100 ticks confirms the hundredths-to-seconds hand-off. A load of all ones shows the fixed-zero masking.

// File: rtl/bcd_tk_pkg.sv
// Shared types and constants for the BCD calendar timekeeper.
// Assumes the register image packs register k into byte k.
package bcd_tk_pkg;

    // Register file, with register 7 packed at the top byte
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hours;
        logic [7:0] minute;
        logic [7:0] second;
        logic [7:0] hundredth;
    } tk_regs_t;

    localparam int TK_REG_COUNT = 8;
    localparam int TK_IMG_W     = TK_REG_COUNT * 8;

    // Bits that hold information; all others read back zero
    localparam logic [TK_IMG_W-1:0] TK_KEEP_MASK = 64'hFF1F_3F37_BF7F_7FFF;
    localparam logic [TK_IMG_W-1:0] TK_RESET_IMG = 64'h0001_0131_0000_0000;

    // Field positions used by the control logic
    localparam int WDAY_HALT_BIT  = 5;
    localparam int WDAY_RSTIG_BIT = 4;
    localparam int HOURS_12H_BIT  = 7;
    localparam int HOURS_PM_BIT   = 5;

    // Last values of the fixed-range counters
    localparam logic [7:0] HUND_LAST  = 8'h99;
    localparam logic [7:0] SEXA_LAST  = 8'h59;
    localparam logic [7:0] MONTH_LAST = 8'h12;
    localparam logic [7:0] YEAR_LAST  = 8'h99;
    localparam logic [7:0] H24_LAST   = 8'h23;
    localparam logic [2:0] WDAY_LAST  = 3'd7;
    localparam logic [2:0] WDAY_FIRST = 3'd1;

endpackage

// File: rtl/bcd_tk_pair.sv
// Two-digit BCD step: gives the value that follows val_i, wrapping to
// FIRST once val_i reaches or passes last_i. Purely combinational.
// Assumes val_i holds valid BCD digits.
module bcd_tk_pair #(
    parameter logic [7:0] FIRST = 8'h00
) (
    input  logic [7:0] val_i,
    input  logic [7:0] last_i,
    output logic [7:0] next_o,
    output logic       at_last_o
);
    // Increment the units digit, carry into the tens digit, or wrap
    always_comb begin
        at_last_o = (val_i >= last_i);
        if (at_last_o) begin
            next_o = FIRST;
        end else if (val_i[3:0] >= 4'd9) begin
            next_o = {val_i[7:4] + 4'd1, 4'h0};
        end else begin
            next_o = {val_i[7:4], val_i[3:0] + 4'd1};
        end
    end
endmodule

// File: rtl/bcd_tk_hours.sv
// Hours step for both formats. Bit 7 picks 12-hour mode, in which bit 5
// is the PM flag; in 24-hour mode bit 5 is the twenties digit.
// day_carry_o flags the step that starts a new day. Combinational.
module bcd_tk_hours
    import bcd_tk_pkg::*;
(
    input  logic [7:0] hours_i,
    output logic [7:0] next_o,
    output logic       day_carry_o
);
    logic pm;
    assign pm = hours_i[HOURS_PM_BIT];

    // Next hour value and end-of-day flag for the selected format
    always_comb begin
        day_carry_o = 1'b0;
        if (hours_i[HOURS_12H_BIT]) begin
            if (hours_i[4:0] == 5'h12) begin
                next_o = {1'b1, 1'b0, pm, 5'h01};
            end else if (hours_i[4:0] >= 5'h11) begin
                next_o      = {1'b1, 1'b0, ~pm, 5'h12};
                day_carry_o = pm;
            end else if (hours_i[3:0] >= 4'd9) begin
                next_o = {1'b1, 1'b0, pm, 5'h10};
            end else begin
                next_o = {1'b1, 1'b0, pm, hours_i[4], hours_i[3:0] + 4'd1};
            end
        end else begin
            if ({2'b00, hours_i[5:0]} >= H24_LAST) begin
                next_o      = 8'h00;
                day_carry_o = 1'b1;
            end else if (hours_i[3:0] >= 4'd9) begin
                next_o = {2'b00, hours_i[5:4] + 2'd1, 4'h0};
            end else begin
                next_o = {2'b00, hours_i[5:4], hours_i[3:0] + 4'd1};
            end
        end
    end
endmodule

// File: rtl/bcd_tk_month_len.sv
// Last date of a month in BCD, with February following the
// divisible-by-four rule applied to the two-digit BCD year.
// Combinational.
module bcd_tk_month_len (
    input  logic [7:0] month_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_o
);
    logic leap;

    // Divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
    always_comb begin
        if (year_i[4]) begin
            leap = (year_i[3:0] == 4'd2) || (year_i[3:0] == 4'd6);
        end else begin
            leap = (year_i[3:0] == 4'd0) || (year_i[3:0] == 4'd4) ||
                   (year_i[3:0] == 4'd8);
        end
    end

    // Choose the month length
    always_comb begin
        case (month_i)
            8'h02:                      last_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
            default:                    last_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_timekeeper.sv
// BCD calendar timekeeper. It counts hundredths through years on a
// 100 Hz tick enable, accepts a one-cycle bulk load of all eight
// registers (the load beats a tick in the same cycle), and holds the
// halt and reset-ignore controls in the day-of-week register.
// Assumes at most one tick per clock cycle and that loaded values are
// valid BCD. The whole carry chain settles within one cycle.
module bcd_timekeeper
    import bcd_tk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                load_i,
    input  logic [TK_IMG_W-1:0] load_image_i,
    output logic [TK_IMG_W-1:0] image_o
);
    tk_regs_t cur, nxt;

    logic [7:0] hund_nx, sec_nx, min_nx, hr_nx, date_nx, mon_nx, yr_nx;
    logic       hund_end, sec_end, min_end, hr_end, date_end, mon_end, yr_end;
    logic [7:0] month_last;
    logic       run, c_sec, c_min, c_hr, c_day, c_mon, c_yr;

    // Fixed-range counters, one per field
    bcd_tk_pair #(.FIRST(8'h00)) u_hund (
        .val_i(cur.hundredth), .last_i(HUND_LAST),
        .next_o(hund_nx), .at_last_o(hund_end));

    bcd_tk_pair #(.FIRST(8'h00)) u_sec (
        .val_i(cur.second), .last_i(SEXA_LAST),
        .next_o(sec_nx), .at_last_o(sec_end));

    bcd_tk_pair #(.FIRST(8'h00)) u_min (
        .val_i(cur.minute), .last_i(SEXA_LAST),
        .next_o(min_nx), .at_last_o(min_end));

    bcd_tk_hours u_hours (
        .hours_i(cur.hours), .next_o(hr_nx), .day_carry_o(hr_end));

    bcd_tk_month_len u_mlen (
        .month_i(cur.month), .year_i(cur.year), .last_o(month_last));

    bcd_tk_pair #(.FIRST(8'h01)) u_date (
        .val_i(cur.date), .last_i(month_last),
        .next_o(date_nx), .at_last_o(date_end));

    bcd_tk_pair #(.FIRST(8'h01)) u_month (
        .val_i(cur.month), .last_i(MONTH_LAST),
        .next_o(mon_nx), .at_last_o(mon_end));

    bcd_tk_pair #(.FIRST(8'h00)) u_year (
        .val_i(cur.year), .last_i(YEAR_LAST),
        .next_o(yr_nx), .at_last_o(yr_end));

    // Ripple enables from hundredths up to years
    always_comb begin
        run   = tick_i & ~cur.wday[WDAY_HALT_BIT];
        c_sec = run   & hund_end;
        c_min = c_sec & sec_end;
        c_hr  = c_min & min_end;
        c_day = c_hr  & hr_end;
        c_mon = c_day & date_end;
        c_yr  = c_mon & mon_end;
    end

    // Assemble the next register file from the enabled fields
    always_comb begin
        nxt = cur;
        if (run)   nxt.hundredth = hund_nx;
        if (c_sec) nxt.second    = sec_nx;
        if (c_min) nxt.minute    = min_nx;
        if (c_hr)  nxt.hours     = hr_nx;
        if (c_day) begin
            nxt.date = date_nx;
            if (cur.wday[2:0] >= WDAY_LAST) begin
                nxt.wday = {cur.wday[7:3], WDAY_FIRST};
            end else begin
                nxt.wday = {cur.wday[7:3], cur.wday[2:0] + 3'd1};
            end
        end
        if (c_mon) nxt.month = mon_nx;
        if (c_yr)  nxt.year  = yr_nx;
    end

    // State register: reset first, then load, then count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= tk_regs_t'(TK_RESET_IMG);
        end else if (load_i) begin
            cur <= tk_regs_t'(load_image_i & TK_KEEP_MASK);
        end else begin
            cur <= nxt;
        end
    end

    assign image_o = cur;
endmodule

// File: rtl/bcd_tk_checker.sv
// Temporal checks on the timekeeper's ports, bound to every instance.
module bcd_tk_checker
    import bcd_tk_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                tick_i,
    input logic                load_i,
    input logic [TK_IMG_W-1:0] load_image_i,
    input logic [TK_IMG_W-1:0] image_o
);
    AST_FIXED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (image_o & ~TK_KEEP_MASK) == '0); // R11

    AST_LOAD_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> image_o == ($past(load_image_i) & TK_KEEP_MASK)); // R11

    AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && tick_i) |=> image_o == ($past(load_image_i) & TK_KEEP_MASK)); // R12

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(image_o)); // R1

    AST_HUND_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && tick_i && !image_o[32+WDAY_HALT_BIT])
        |=> image_o[7:0] != $past(image_o[7:0])); // R1

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && image_o[32+WDAY_HALT_BIT]) |=> $stable(image_o)); // R8

    AST_CTRL_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(image_o[37:36])); // R9
endmodule

bind bcd_timekeeper bcd_tk_checker u_bcd_tk_checker (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
    .load_image_i(load_image_i), .image_o(image_o));

// File: tb/bcd_timekeeper_test.sv
// Self-checking bench: a table of single-tick boundary cases, then
// directed tests for reset, halt, load priority and masking.
module bcd_timekeeper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        load_i = 1'b0;
    logic [63:0] load_image_i = '0;
    logic [63:0] image_o;

    int errors = 0;
    int checks = 0;

    bcd_timekeeper uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
        .load_image_i(load_image_i), .image_o(image_o));

    always #5 clk = ~clk;

    // {requirement number, start image, image after one tick}
    localparam int NV = 24;
    localparam logic [135:0] VECS [NV] = '{
        {8'd1, 64'h2403_1513_1020_3041, 64'h2403_1513_1020_3042}, // R1
        {8'd1, 64'h2403_1513_1020_3049, 64'h2403_1513_1020_3050}, // R1
        {8'd2, 64'h2403_1513_1020_3099, 64'h2403_1513_1020_3100}, // R2
        {8'd2, 64'h2403_1513_1020_5999, 64'h2403_1513_1021_0000}, // R2
        {8'd3, 64'h2403_1513_1059_5999, 64'h2403_1513_1100_0000}, // R3
        {8'd3, 64'h2403_1513_0959_5999, 64'h2403_1513_1000_0000}, // R3
        {8'd3, 64'h2403_1513_1959_5999, 64'h2403_1513_2000_0000}, // R3
        {8'd3, 64'h2403_1503_2359_5999, 64'h2403_1604_0000_0000}, // R3
        {8'd4, 64'h2403_1513_9259_5999, 64'h2403_1513_8100_0000}, // R4
        {8'd4, 64'h2403_1513_9159_5999, 64'h2403_1513_B200_0000}, // R4
        {8'd4, 64'h2403_1513_B159_5999, 64'h2403_1614_9200_0000}, // R4
        {8'd4, 64'h2403_1513_A959_5999, 64'h2403_1513_B000_0000}, // R4
        {8'd5, 64'h2403_1517_2359_5999, 64'h2403_1611_0000_0000}, // R5
        {8'd6, 64'h2404_3013_2359_5999, 64'h2405_0114_0000_0000}, // R6
        {8'd6, 64'h2401_3013_2359_5999, 64'h2401_3114_0000_0000}, // R6
        {8'd6, 64'h2411_3013_2359_5999, 64'h2412_0114_0000_0000}, // R6
        {8'd6, 64'h9912_3113_2359_5999, 64'h0001_0114_0000_0000}, // R6
        {8'd6, 64'h2412_3113_2359_5999, 64'h2501_0114_0000_0000}, // R6
        {8'd7, 64'h2402_2813_2359_5999, 64'h2402_2914_0000_0000}, // R7
        {8'd7, 64'h2402_2913_2359_5999, 64'h2403_0114_0000_0000}, // R7
        {8'd7, 64'h2302_2813_2359_5999, 64'h2303_0114_0000_0000}, // R7
        {8'd7, 64'h0002_2813_2359_5999, 64'h0002_2914_0000_0000}, // R7
        {8'd7, 64'h1002_2813_2359_5999, 64'h1003_0114_0000_0000}, // R7
        {8'd7, 64'h1202_2813_2359_5999, 64'h1202_2914_0000_0000}  // R7
    };

    // Compare and report one result
    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One-cycle bulk load, optionally with a tick in the same cycle
    task automatic do_load(input logic [63:0] img, input logic with_tick);
        @(negedge clk);
        load_i = 1'b1;
        load_image_i = img;
        tick_i = with_tick;
        @(negedge clk);
        load_i = 1'b0;
        tick_i = 1'b0;
    endtask

    // n consecutive tick cycles
    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(image_o, 64'h0001_0131_0000_0000, "R10 reset image");
        check({62'd0, image_o[37:36]}, 64'd3, "R9 controls set after reset");

        ticks(5);
        check(image_o, 64'h0001_0131_0000_0000, "R8 halted after reset");

        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i][127:64], 1'b0);
            ticks(1);
            check(image_o, VECS[i][63:0], $sformatf("R%0d table row %0d", VECS[i][135:128], i));
        end

        do_load(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        check(image_o, 64'hFF1F_3F37_BF7F_7FFF, "R11 fixed bits masked");

        do_load(64'h2403_1513_1020_3041, 1'b1);
        check(image_o, 64'h2403_1513_1020_3041, "R12 load beats tick");

        repeat (5) @(negedge clk);
        check(image_o, 64'h2403_1513_1020_3041, "R1 holds without tick");

        do_load(64'h2403_1533_1020_3041, 1'b0);
        ticks(3);
        check(image_o, 64'h2403_1533_1020_3041, "R8 halt bit blocks ticks");

        do_load(64'h2403_1513_1020_3000, 1'b0);
        ticks(100);
        check(image_o, 64'h2403_1513_1020_3100, "R1 hundred ticks make a second");

        do_load(64'h2403_1513_2359_5999, 1'b0);
        ticks(1);
        check({56'd0, image_o[39:32]}, 64'h14, "R9 reset-ignore kept across day advance");

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(image_o, 64'h0001_0131_0000_0000, "R10 reset while running");

        finish_run();
    end
endmodule